// File: doc/BRIEF.md
# RGB555 Display Fade Stage

This block sits on the display output path between the frame store and the video encoder. Each 15-bit colour pixel read from the page on show is brightened or darkened by a per-channel offset taken from a 16-bit fade word. The pixel is then emitted one clock later with a matching valid strobe. Every channel saturates at black and at full intensity, so a fade sweep never wraps around.

The fade word uses sign-magnitude form. Its three 5-bit magnitudes sit in the same fields as the pixel's colour channels. A single sign bit chooses whether all three magnitudes are added (brighten) or subtracted (darken). An all-zero fade word selects a bypass path.

The block also derives the read-page select for the double-buffered frame store. The page shown is always the opposite of the page being drawn.

Top module: `rgb_fade_stage`

## Requirements
- R1: A pixel holds blue in bits 4:0, green in bits 9:5 and red in bits 14:10. Bit 15 of every output pixel is zero.
- R2: When fade bit 15 is 0 and the fade word is nonzero, each output channel equals the input channel plus the matching fade magnitude, limited to 31.
- R3: When fade bit 15 is 1, each output channel equals the input channel minus the matching fade magnitude, limited to 0.
- R4: When the fade word is 0x0000, the output pixel equals the input pixel with bit 15 cleared.
- R5: A fade word of 0x8000 (sign set, all magnitudes zero) leaves bits 14:0 of the pixel unchanged.
- R6: pix_out_valid equals pix_in_valid from one clock earlier. The matching result is on pix_out in that same cycle.
- R7: While pix_in_valid is low, pix_out holds the last result.
- R8: show_page is the inverse of draw_page and follows it with no clock delay.
- R9: While reset is asserted, pix_out_valid and pix_out are zero.
- R10: The fade word is sampled together with each pixel. A change of the fade word applies from the pixel accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in_valid | input | 1 | Input pixel strobe |
| pix_in | input | 16 | Input pixel, colour in bits 14:0 |
| fade_word | input | 16 | Three 5-bit magnitudes plus sign in bit 15 |
| draw_page | input | 1 | Page currently being drawn |
| pix_out_valid | output | 1 | Output pixel strobe |
| pix_out | output | 16 | Faded pixel |
| show_page | output | 1 | Page to read for display |

## Verification
Each pixel result and its valid strobe are due exactly one rising edge after the pixel is presented. The page select is due at once, with no clock edge.

The bench drives stimulus on the falling edge and checks the registered outputs on the next falling edge, against a model result kept from the previous drive. It checks show_page a short delay after changing draw_page, with no edge in between. Idle cycles are checked against the last held result, so the checks for R7 and R6 line up with the same one-cycle offset.

// File: rtl/rgb_fade_pkg.sv
package rgb_fade_pkg;
   localparam int CHAN_W_DEF   = 5;
   localparam int NUM_CHAN_DEF = 3;
   localparam int PIX_W_DEF    = 16;

   // headroom bits so a sum or difference never wraps before the clamp
   localparam int GUARD_BITS = 2;

   typedef enum logic {
      FADE_UP   = 1'b0,
      FADE_DOWN = 1'b1
   } fade_dir_e;
endpackage

// File: rtl/rgb_fade_chan.sv
module rgb_fade_chan
   import rgb_fade_pkg::*;
#(
   parameter int CHAN_W = CHAN_W_DEF
) (
   input  logic [CHAN_W-1:0] src,
   input  logic [CHAN_W-1:0] mag,
   input  fade_dir_e         dir,
   output logic [CHAN_W-1:0] res
);
   localparam int IW = CHAN_W + GUARD_BITS;
   localparam logic signed [IW-1:0] CEIL = signed'({{GUARD_BITS{1'b0}}, {CHAN_W{1'b1}}});

   if (CHAN_W < 2) begin : g_bad_w
      $error("rgb_fade_chan: CHAN_W must be at least 2");
   end

   logic signed [IW-1:0] src_s;
   logic signed [IW-1:0] off_s;
   logic signed [IW-1:0] sum_s;

   always_comb begin
      src_s = signed'({{GUARD_BITS{1'b0}}, src});
      off_s = signed'({{GUARD_BITS{1'b0}}, mag});
      if (dir == FADE_DOWN) begin
         off_s = -off_s;
      end
      sum_s = src_s + off_s;
      if (sum_s < 0) begin
         res = '0;
      end else if (sum_s > CEIL) begin
         res = '1;
      end else begin
         res = sum_s[CHAN_W-1:0];
      end
   end
endmodule

// File: rtl/rgb_fade_page.sv
module rgb_fade_page #(
   parameter bit PAGE_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic draw_page,
   output logic show_page
);
   if (PAGE_REG) begin : g_reg
      logic page_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            page_q <= 1'b1;
         end else begin
            page_q <= ~draw_page;
         end
      end
      assign show_page = page_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign show_page  = ~draw_page;
   end
endmodule

// File: rtl/rgb_fade_stage.sv
module rgb_fade_stage
   import rgb_fade_pkg::*;
#(
   parameter int CHAN_W   = CHAN_W_DEF,
   parameter int NUM_CHAN = NUM_CHAN_DEF,
   parameter int PIX_W    = PIX_W_DEF,
   parameter bit PAGE_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_in_valid,
   input  logic [PIX_W-1:0] pix_in,
   input  logic [PIX_W-1:0] fade_word,
   input  logic             draw_page,
   output logic             pix_out_valid,
   output logic [PIX_W-1:0] pix_out,
   output logic             show_page
);
   localparam int COLOR_W  = CHAN_W * NUM_CHAN;
   localparam int SIGN_BIT = PIX_W - 1;

   if (PIX_W < COLOR_W + 1) begin : g_bad_pix
      $error("rgb_fade_stage: PIX_W too small for channels plus sign");
   end
   if (NUM_CHAN < 1) begin : g_bad_n
      $error("rgb_fade_stage: NUM_CHAN must be positive");
   end

   fade_dir_e            dir;
   logic [COLOR_W-1:0]   chan_res;
   logic                 fade_off;
   logic [PIX_W-1:0]     next_pix;
   logic [PIX_W-1:0]     pix_q;
   logic                 vld_q;

   assign dir      = fade_dir_e'(fade_word[SIGN_BIT]);
   assign fade_off = (fade_word == '0);

   for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
      rgb_fade_chan #(
         .CHAN_W(CHAN_W)
      ) chan_i (
         .src(pix_in[ch*CHAN_W +: CHAN_W]),
         .mag(fade_word[ch*CHAN_W +: CHAN_W]),
         .dir(dir),
         .res(chan_res[ch*CHAN_W +: CHAN_W])
      );
   end

   always_comb begin
      next_pix = '0;
      if (fade_off) begin
         next_pix[COLOR_W-1:0] = pix_in[COLOR_W-1:0];
      end else begin
         next_pix[COLOR_W-1:0] = chan_res;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         pix_q <= '0;
      end else begin
         vld_q <= pix_in_valid;
         if (pix_in_valid) begin
            pix_q <= next_pix;
         end
      end
   end

   assign pix_out_valid = vld_q;
   assign pix_out       = pix_q;

   rgb_fade_page #(
      .PAGE_REG(PAGE_REG)
   ) page_i (
      .clk(clk),
      .rst_n(rst_n),
      .draw_page(draw_page),
      .show_page(show_page)
   );
endmodule

// File: rtl/rgb_fade_stage_chk.sv
module rgb_fade_stage_chk #(
   parameter int PIX_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_in_valid,
   input logic [PIX_W-1:0] pix_in,
   input logic [PIX_W-1:0] fade_word,
   input logic             pix_out_valid,
   input logic [PIX_W-1:0] pix_out
);
   logic up_take;
   logic down_take;
   assign up_take   = pix_in_valid && (fade_word != '0) && !fade_word[15];
   assign down_take = pix_in_valid && fade_word[15];

   assert_sign_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pix_in_valid) |-> (pix_out[15] == 1'b0));

   assert_brighten_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(up_take) |->
         (pix_out[4:0] >= $past(pix_in[4:0])) &&
         (pix_out[9:5] >= $past(pix_in[9:5])) &&
         (pix_out[14:10] >= $past(pix_in[14:10])));

   assert_darken_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(down_take) |->
         (pix_out[4:0] <= $past(pix_in[4:0])) &&
         (pix_out[9:5] <= $past(pix_in[9:5])) &&
         (pix_out[14:10] <= $past(pix_in[14:10])));

   assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pix_in_valid && (fade_word == '0)) |->
         (pix_out[14:0] == $past(pix_in[14:0])));

   assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pix_out_valid == $past(pix_in_valid)));

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(pix_in_valid)) |-> $stable(pix_out));
endmodule

bind rgb_fade_stage rgb_fade_stage_chk #(
   .PIX_W(PIX_W)
) chk_i (
   .clk(clk),
   .rst_n(rst_n),
   .pix_in_valid(pix_in_valid),
   .pix_in(pix_in),
   .fade_word(fade_word),
   .pix_out_valid(pix_out_valid),
   .pix_out(pix_out)
);

// File: tb/rgb_fade_stage_tb_top.sv
module rgb_fade_stage_tb_top;
   logic        clk;
   logic        rst_n;
   logic        pix_in_valid;
   logic [15:0] pix_in;
   logic [15:0] fade_word;
   logic        draw_page;
   logic        pix_out_valid;
   logic [15:0] pix_out;
   logic        show_page;

   int checks = 0;
   int errors = 0;

   logic        exp_vld;
   logic [15:0] exp_pix;

   rgb_fade_stage dut_i (
      .clk(clk),
      .rst_n(rst_n),
      .pix_in_valid(pix_in_valid),
      .pix_in(pix_in),
      .fade_word(fade_word),
      .draw_page(draw_page),
      .pix_out_valid(pix_out_valid),
      .pix_out(pix_out),
      .show_page(show_page)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   function automatic logic [15:0] model(input logic [15:0] p, input logic [15:0] f);
      logic [15:0] r;
      if (f == 16'h0000) return {1'b0, p[14:0]};
      r = 16'h0000;
      for (int c = 0; c < 3; c++) begin
         int s;
         int m;
         s = int'(p[c*5 +: 5]);
         m = int'(f[c*5 +: 5]);
         s = f[15] ? s - m : s + m;
         if (s < 0) s = 0;
         if (s > 31) s = 31;
         r[c*5 +: 5] = 5'(s);
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one stimulus at a falling edge, check its result at the next
   task automatic step(input string req, input logic v, input logic [15:0] p,
                       input logic [15:0] f);
      pix_in_valid = v;
      pix_in       = p;
      fade_word    = f;
      exp_vld      = v;
      if (v) exp_pix = model(p, f);
      @(negedge clk);
      chk({req, " R6 valid"}, {15'd0, pix_out_valid}, {15'd0, exp_vld});
      chk(req, pix_out, exp_pix);
   endtask

   initial begin
      #3000000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_F00D));
      rst_n = 1'b0;
      pix_in_valid = 1'b1;
      pix_in = 16'hFFFF;
      fade_word = 16'h0000;
      draw_page = 1'b0;
      exp_pix = 16'h0000;
      repeat (3) @(negedge clk);
      chk("R9 reset valid", {15'd0, pix_out_valid}, 16'h0000);
      chk("R9 reset pixel", pix_out, 16'h0000);
      pix_in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R8 page select, no clock between change and sample
      draw_page = 1'b0; #1;
      chk("R8 page0", {15'd0, show_page}, 16'h0001);
      draw_page = 1'b1; #1;
      chk("R8 page1", {15'd0, show_page}, 16'h0000);

      // directed corners
      step("R4 bypass bit15", 1'b1, 16'hFBCD, 16'h0000);
      chk("R4 bypass exact", pix_out, 16'h7BCD);
      step("R5 negative zero", 1'b1, 16'h9234, 16'h8000);
      chk("R5 exact", pix_out, 16'h1234);
      step("R2 saturate high", 1'b1, 16'h7BDE, 16'h0C63);
      chk("R2 exact", pix_out, 16'h7FFF);
      step("R2 no saturate", 1'b1, {1'b0, 5'd3, 5'd4, 5'd5}, {1'b0, 5'd1, 5'd2, 5'd3});
      chk("R2 exact sum", pix_out, {1'b0, 5'd4, 5'd6, 5'd8});
      step("R3 saturate low", 1'b1, {1'b0, 5'd2, 5'd10, 5'd31}, {1'b1, 5'd5, 5'd10, 5'd1});
      chk("R3 exact", pix_out, {1'b0, 5'd0, 5'd0, 5'd30});
      step("R1 sign cleared", 1'b1, 16'hFFFF, 16'h0421);
      chk("R1 bit15", {15'd0, pix_out[15]}, 16'h0000);
      step("R7 idle hold", 1'b0, 16'h1111, 16'h0421);
      step("R7 idle hold2", 1'b0, 16'h2222, 16'h8421);
      // R10: fade changes every cycle
      step("R10 fade a", 1'b1, 16'h4210, 16'h0001);
      step("R10 fade b", 1'b1, 16'h4210, 16'h8400);
      step("R10 fade c", 1'b1, 16'h4210, 16'h0000);

      // constrained random with idle gaps
      for (int i = 0; i < 400; i++) begin
         logic [15:0] p;
         logic [15:0] f;
         logic v;
         p = 16'($urandom);
         f = 16'($urandom);
         if (($urandom % 8) == 0) f = 16'h0000;
         v = (($urandom % 4) != 0);
         step(f[15] ? "R3 random" : "R2 random", v, p, f);
         if (($urandom % 16) == 0) begin
            draw_page = ~draw_page; #1;
            chk("R8 random", {15'd0, show_page}, {15'd0, ~draw_page});
         end
      end

      pix_in_valid = 1'b0;
      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule